// File: doc/BRIEF.md
# Rectifier Gate Shrink Protection Logic

This block guards the secondary-side synchronous rectifier of a resonant converter against shoot-through. It watches the rectifier gate, the digitised drain-sense comparator and a sampled opto-feedback current. From these it decides, once per switching cycle, by how many clock cycles the next gate pulse must be cut short. The gate timer supplies the on-time it predicted from the last conduction interval and receives the shortened on-time back, or a flag that suppresses the pulse.

Three detectors run side by side, each with its own fixed penalty. The first flags too little dead time: the sense input rises shortly after the gate was switched off. The second flags a fast load step: a feedback sample exceeds the previous one by more than a fifth. This penalty stays in force for a fixed hold window. The third flags light-load ringing: the sense input bounces back high soon after falling and stays high long enough. The dead-time and ringing penalties apply to a single switching cycle. When several penalties are active, the largest one is used; they are never summed.

Top module: `srgs_gate_shrink`

## Requirements
- R1: A rising edge of `det_hi` sampled at offset k = 0..DT_WIN-1 clock edges after the first edge that samples `gate_on` low (following a high sample) arms the dead-time penalty. DT_SHRINK is applied from the next `cyc_strobe` on. A rise at offset DT_WIN or later arms nothing.
- R2: A dead-time or ringing penalty latched at one `cyc_strobe` is removed at the following `cyc_strobe` unless a new event arms it again.
- R3: On each `fb_valid` the sample is compared with the previous one. A trigger occurs when 5 × new > 6 × previous. The first sample after reset is only stored and never triggers.
- R4: A feedback trigger applies FB_SHRINK for FB_HOLD clock cycles. A trigger inside the window restarts the full window.
- R5: A ringing event arms RING_SHRINK for the next `cyc_strobe`. The event is `det_hi` falling, then rising on one of the next RING_WIN sampled edges, then being sampled high on more than RING_HIGH consecutive edges.
- R6: While `dead_cfg` is below DT_WIN, DT_SHRINK is applied continuously.
- R7: The applied shrink is the largest active penalty (0, DT_SHRINK, FB_SHRINK or RING_SHRINK), never a sum.
- R8: `on_cyc` = `pred_on` − `shrink_cyc` when `pred_on` > `shrink_cyc`. Otherwise `on_cyc` = 0 and `gate_block` = 1.
- R9: While `rst` is high, `shrink_cyc`, `on_cyc` and `gate_block` are 0.
- R10: All outputs are registered. They reflect the inputs and state sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_on | input | 1 | Present rectifier gate drive level |
| det_hi | input | 1 | Drain-sense comparator, 1 = above threshold |
| cyc_strobe | input | 1 | One-cycle pulse when the gate timer loads its next on-time |
| fb_valid | input | 1 | Qualifies `fb_sample` for one cycle |
| fb_sample | input | FB_W | Digitised feedback current |
| dead_cfg | input | CNT_W | Configured dead time in clock cycles |
| pred_on | input | CNT_W | Predicted on-time in clock cycles |
| shrink_cyc | output | CNT_W | Applied shrink amount in clock cycles |
| on_cyc | output | CNT_W | Shortened on-time in clock cycles |
| gate_block | output | 1 | Pulse suppressed for this cycle |

## Verification
The assertions check four things on every cycle: the arithmetic link between the predicted on-time, the shrink and the shortened on-time; that the shrink is always exactly one of the legal amounts; that an active feedback hold never yields less than its penalty; and the counter bounds inside the detectors. The window edges can only be shown by the bench's scenarios: dead-time offsets DT_WIN−1 against DT_WIN, ringing rise at RING_WIN against RING_WIN+1, and high durations of RING_HIGH against RING_HIGH+1. The same holds for the exact end of the feedback hold, its restart, and the one-cycle lifetime of the latched penalties.

// File: rtl/srgs_pkg.sv
package srgs_pkg;

  typedef enum logic [1:0] {
    RG_IDLE  = 2'd0,
    RG_LOWW  = 2'd1,
    RG_HIGHW = 2'd2
  } ring_st_t;

  localparam int N_SRC = 3;

endpackage

// File: rtl/srgs_deadtime_det.sv
module srgs_deadtime_det #(
  parameter int DT_WIN = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_on,
  input  logic det_hi,
  input  logic strobe,
  output logic applied
);
  localparam int WW = $clog2(DT_WIN + 1);

  logic          gate_q, det_q, pend;
  logic [WW-1:0] wcnt;
  logic          fall, rise, in_win, ev;

  assign fall   = gate_q & ~gate_on;
  assign rise   = det_hi & ~det_q;
  assign in_win = fall | (wcnt != '0);
  assign ev     = rise & in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      det_q   <= 1'b1;
      wcnt    <= '0;
      pend    <= 1'b0;
      applied <= 1'b0;
    end else begin
      gate_q <= gate_on;
      det_q  <= det_hi;
      if (fall)
        wcnt <= WW'(DT_WIN - 1);
      else if (wcnt != '0)
        wcnt <= wcnt - 1'b1;
      if (strobe) begin
        applied <= pend;
        pend    <= ev;
      end else if (ev) begin
        pend <= 1'b1;
      end
    end
  end

  // R1: the window counter never exceeds its span
  a_r1_window_bound: assert property (@(posedge clk) disable iff (rst)
    wcnt <= WW'(DT_WIN - 1));

endmodule

// File: rtl/srgs_ring_det.sv
module srgs_ring_det
  import srgs_pkg::*;
#(
  parameter int RING_WIN  = 87,
  parameter int RING_HIGH = 37
) (
  input  logic clk,
  input  logic rst,
  input  logic det_hi,
  input  logic strobe,
  output logic applied
);
  localparam int CMAX = (RING_WIN > RING_HIGH) ? RING_WIN : RING_HIGH;
  localparam int CW   = $clog2(CMAX + 1);

  ring_st_t      st;
  logic [CW-1:0] cnt;
  logic          det_q, pend, ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RG_IDLE;
      cnt     <= '0;
      det_q   <= 1'b1;
      pend    <= 1'b0;
      applied <= 1'b0;
    end else begin
      det_q <= det_hi;
      unique case (st)
        RG_IDLE: begin
          if (det_q && !det_hi) begin
            st  <= RG_LOWW;
            cnt <= CW'(1);
          end
        end
        RG_LOWW: begin
          if (det_hi) begin
            st  <= RG_HIGHW;
            cnt <= CW'(1);
          end else if (cnt == CW'(RING_WIN)) begin
            st <= RG_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RG_HIGHW: begin
          if (!det_hi) begin
            st  <= RG_LOWW;
            cnt <= CW'(1);
          end else if (cnt == CW'(RING_HIGH)) begin
            st <= RG_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RG_IDLE;
      endcase
      if (strobe) begin
        applied <= pend;
        pend    <= ev;
      end else if (ev) begin
        pend <= 1'b1;
      end
    end
  end

  assign ev = (st == RG_HIGHW) && det_hi && (cnt == CW'(RING_HIGH));

  // R5: the high-duration count stays inside its limit
  a_r5_high_bound: assert property (@(posedge clk) disable iff (rst)
    (st == RG_HIGHW) |-> (cnt <= CW'(RING_HIGH)));

  // R5: the low watch never runs beyond its window
  a_r5_low_bound: assert property (@(posedge clk) disable iff (rst)
    (st == RG_LOWW) |-> (cnt <= CW'(RING_WIN)));

endmodule

// File: rtl/srgs_fb_det.sv
module srgs_fb_det #(
  parameter int FB_W    = 12,
  parameter int FB_HOLD = 22500
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fb_valid,
  input  logic [FB_W-1:0] fb_sample,
  output logic            active
);
  localparam int HW = $clog2(FB_HOLD + 1);
  localparam int MW = FB_W + 3;

  logic [FB_W-1:0] prev;
  logic            prev_ok, trig;
  logic [HW-1:0]   hold;
  logic [MW-1:0]   lhs, rhs;

  assign lhs    = MW'(fb_sample) * MW'(5);
  assign rhs    = MW'(prev) * MW'(6);
  assign trig   = fb_valid && prev_ok && (lhs > rhs);
  assign active = (hold != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= '0;
      prev_ok <= 1'b0;
      hold    <= '0;
    end else begin
      if (fb_valid) begin
        prev    <= fb_sample;
        prev_ok <= 1'b1;
      end
      if (trig)
        hold <= HW'(FB_HOLD);
      else if (hold != '0)
        hold <= hold - 1'b1;
    end
  end

  // R3: the very first sample after reset does not start a hold
  a_r3_first_store: assert property (@(posedge clk) disable iff (rst)
    (fb_valid && !prev_ok && hold == '0) |=> (hold == '0));

  // R4: the hold count never exceeds the window length
  a_r4_hold_bound: assert property (@(posedge clk) disable iff (rst)
    hold <= HW'(FB_HOLD));

endmodule

// File: rtl/srgs_shrink_sel.sv
module srgs_shrink_sel
  import srgs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DT_SHRINK   = 312,
  parameter int FB_SHRINK   = 350,
  parameter int RING_SHRINK = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_on,
  input  logic [CNT_W-1:0] pred_on,
  output logic [CNT_W-1:0] shrink_cyc,
  output logic [CNT_W-1:0] on_cyc,
  output logic             gate_block
);
  logic [CNT_W-1:0] amt   [N_SRC];
  logic [CNT_W-1:0] stage [N_SRC+1];
  logic [CNT_W-1:0] sel;

  assign amt[0] = CNT_W'(DT_SHRINK);
  assign amt[1] = CNT_W'(FB_SHRINK);
  assign amt[2] = CNT_W'(RING_SHRINK);
  assign stage[0] = '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_max
    assign stage[i+1] = (src_on[i] && amt[i] > stage[i]) ? amt[i] : stage[i];
  end

  assign sel = stage[N_SRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      shrink_cyc <= '0;
      on_cyc     <= '0;
      gate_block <= 1'b0;
    end else begin
      shrink_cyc <= sel;
      if (pred_on > sel) begin
        on_cyc     <= pred_on - sel;
        gate_block <= 1'b0;
      end else begin
        on_cyc     <= '0;
        gate_block <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/srgs_gate_shrink.sv
module srgs_gate_shrink
  import srgs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FB_W        = 12,
  parameter int DT_WIN      = 31,
  parameter int DT_SHRINK   = 312,
  parameter int FB_SHRINK   = 350,
  parameter int FB_HOLD     = 22500,
  parameter int RING_WIN    = 87,
  parameter int RING_HIGH   = 37,
  parameter int RING_SHRINK = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_on,
  input  logic             det_hi,
  input  logic             cyc_strobe,
  input  logic             fb_valid,
  input  logic [FB_W-1:0]  fb_sample,
  input  logic [CNT_W-1:0] dead_cfg,
  input  logic [CNT_W-1:0] pred_on,
  output logic [CNT_W-1:0] shrink_cyc,
  output logic [CNT_W-1:0] on_cyc,
  output logic             gate_block
);
  logic dt_app, ring_app, fb_on, dt_static;
  logic [N_SRC-1:0] src_on;

  srgs_deadtime_det #(.DT_WIN(DT_WIN)) u_dt (
    .clk(clk), .rst(rst), .gate_on(gate_on), .det_hi(det_hi),
    .strobe(cyc_strobe), .applied(dt_app));

  srgs_ring_det #(.RING_WIN(RING_WIN), .RING_HIGH(RING_HIGH)) u_ring (
    .clk(clk), .rst(rst), .det_hi(det_hi),
    .strobe(cyc_strobe), .applied(ring_app));

  srgs_fb_det #(.FB_W(FB_W), .FB_HOLD(FB_HOLD)) u_fb (
    .clk(clk), .rst(rst), .fb_valid(fb_valid), .fb_sample(fb_sample),
    .active(fb_on));

  assign dt_static = (dead_cfg < CNT_W'(DT_WIN));
  assign src_on    = {ring_app, fb_on, dt_app | dt_static};

  srgs_shrink_sel #(
    .CNT_W(CNT_W), .DT_SHRINK(DT_SHRINK),
    .FB_SHRINK(FB_SHRINK), .RING_SHRINK(RING_SHRINK)
  ) u_sel (
    .clk(clk), .rst(rst), .src_on(src_on), .pred_on(pred_on),
    .shrink_cyc(shrink_cyc), .on_cyc(on_cyc), .gate_block(gate_block));

  logic chk_live;
  always_ff @(posedge clk) begin
    if (rst) chk_live <= 1'b0;
    else     chk_live <= 1'b1;
  end

  // R8: a blocked pulse carries no on-time
  a_r8_block_zero: assert property (@(posedge clk) disable iff (rst)
    gate_block |-> (on_cyc == '0));

  // R8, R10: shortened time plus shrink equals last cycle's prediction
  a_r8_sum: assert property (@(posedge clk) disable iff (rst)
    (chk_live && !gate_block) |->
      ((CNT_W+1)'(on_cyc) + (CNT_W+1)'(shrink_cyc) == (CNT_W+1)'($past(pred_on))));

  // R7: only one legal amount is ever applied
  a_r7_legal_amount: assert property (@(posedge clk) disable iff (rst)
    (shrink_cyc == '0) || (shrink_cyc == CNT_W'(DT_SHRINK)) ||
    (shrink_cyc == CNT_W'(FB_SHRINK)) || (shrink_cyc == CNT_W'(RING_SHRINK)));

  // R4: an active feedback hold is never undercut
  a_r4_fb_floor: assert property (@(posedge clk) disable iff (rst)
    $past(fb_on) |-> (shrink_cyc >= CNT_W'(FB_SHRINK)));

endmodule

// File: tb/sim_srgs_gate_shrink.sv
module sim_srgs_gate_shrink;
  localparam int CNT_W = 16, FB_W = 12;
  localparam int DT_WIN = 31, DT_SH = 312, FB_SH = 350, FB_HOLD = 22500;
  localparam int RING_WIN = 87, RING_HIGH = 37, RING_SH = 300;

  logic clk = 1'b0, rst = 1'b1;
  logic gate_on = 1'b0, det_hi = 1'b1, cyc_strobe = 1'b0, fb_valid = 1'b0;
  logic [FB_W-1:0]  fb_sample = '0;
  logic [CNT_W-1:0] dead_cfg = 16'd100, pred_on = 16'd1000;
  logic [CNT_W-1:0] shrink_cyc, on_cyc;
  logic gate_block;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  srgs_gate_shrink u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run exceeded cycle limit (actual %0d, expected < 190000)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int exp_on(input int pred, input int sh);
    return (pred > sh) ? pred - sh : 0;
  endfunction

  function automatic bit exp_fb(input int prev, input int cur);
    return (5 * cur) > (6 * prev);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int sh, input int pred);
    chk({req, " shrink"}, int'(shrink_cyc), sh);
    chk({req, " on"}, int'(on_cyc), exp_on(pred, sh));
    chk({req, " block"}, int'(gate_block), (pred > sh) ? 0 : 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; gate_on = 1'b0; det_hi = 1'b1; cyc_strobe = 1'b0;
    fb_valid = 1'b0; dead_cfg = 16'd100; pred_on = 16'd1000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // strobe sampled at one edge, outputs updated at the next; returns at a negedge after it
  task automatic strobe();
    cyc_strobe = 1'b1;
    @(negedge clk);
    cyc_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic fb_send(input int v);
    fb_valid = 1'b1; fb_sample = FB_W'(v);
    @(negedge clk);
    fb_valid = 1'b0;
    @(negedge clk);
  endtask

  // gate falls, then det rises k edges after the first low gate sample
  task automatic dt_event(input int k);
    det_hi = 1'b0;
    repeat (100) @(negedge clk);
    gate_on = 1'b1;
    repeat (20) @(negedge clk);
    gate_on = 1'b0;
    repeat (k) @(negedge clk);
    det_hi = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // det falls, rises after j edges, stays high for h sampled edges, then low
  task automatic ring_event(input int j, input int h);
    det_hi = 1'b0;
    repeat (j) @(negedge clk);
    det_hi = 1'b1;
    repeat (h) @(negedge clk);
    det_hi = 1'b0;
    repeat (RING_WIN + 5) @(negedge clk);
    det_hi = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));

    // R9: outputs held at zero during reset
    @(negedge clk); @(negedge clk);
    chk("R9 shrink in reset", int'(shrink_cyc), 0);
    chk("R9 on in reset", int'(on_cyc), 0);
    chk("R9 block in reset", int'(gate_block), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R10 idle after reset", 0, 1000);

    // R10: a new prediction shows up one edge later
    pred_on = 16'd777;
    @(negedge clk);
    chk_out("R10 pred follows", 0, 777);

    // R1: rise at offset DT_WIN-1 arms, at DT_WIN does not
    do_reset();
    dt_event(DT_WIN - 1);
    chk("R1 not before strobe", int'(shrink_cyc), 0);
    strobe();
    chk_out("R1 last window offset", DT_SH, 1000);
    // R2: cleared at the following strobe
    strobe();
    chk_out("R2 dead-time one cycle", 0, 1000);
    do_reset();
    dt_event(DT_WIN);
    strobe();
    chk_out("R1 outside window", 0, 1000);
    do_reset();
    dt_event(0);
    strobe();
    chk_out("R1 same-edge rise", DT_SH, 1000);

    // R5: ringing edges of the windows
    do_reset();
    ring_event(RING_WIN, RING_HIGH + 1);
    strobe();
    chk_out("R5 rise at window end", RING_SH, 1000);
    strobe();
    chk_out("R2 ring one cycle", 0, 1000);
    do_reset();
    ring_event(RING_WIN + 1, RING_HIGH + 5);
    strobe();
    chk_out("R5 rise too late", 0, 1000);
    do_reset();
    ring_event(10, RING_HIGH);
    strobe();
    chk_out("R5 high too short", 0, 1000);

    // R3: boundary of the 20 percent rule and first-sample behaviour
    do_reset();
    fb_send(3000);
    chk_out("R3 first sample stored only", 0, 1000);
    fb_send(100);
    fb_send(120);
    chk_out("R3 exactly 20 percent", 0, 1000);
    do_reset();
    fb_send(100);
    fb_send(121);
    chk_out("R3 above 20 percent", FB_SH, 1000);

    // R4: hold ends after FB_HOLD cycles
    repeat (FB_HOLD - 1) @(negedge clk);
    chk_out("R4 hold last cycle", FB_SH, 1000);
    @(negedge clk);
    chk_out("R4 hold expired", 0, 1000);

    // R4: retrigger restarts the window
    do_reset();
    fb_send(100);
    fb_send(200);
    repeat (10000) @(negedge clk);
    fb_send(300);
    repeat (FB_HOLD - 1) @(negedge clk);
    chk_out("R4 restarted window", FB_SH, 1000);
    @(negedge clk);
    chk_out("R4 restarted expiry", 0, 1000);

    // R7: largest wins, not the sum
    do_reset();
    fb_send(100);
    fb_send(200);
    ring_event(5, RING_HIGH + 3);
    strobe();
    chk_out("R7 fb over ring", FB_SH, 1000);
    do_reset();
    dead_cfg = 16'd5;
    ring_event(5, RING_HIGH + 3);
    strobe();
    chk_out("R7 dead-time over ring", DT_SH, 1000);

    // R6: small dead time setting
    do_reset();
    dead_cfg = 16'(DT_WIN - 1);
    @(negedge clk);
    chk_out("R6 below window", DT_SH, 1000);
    dead_cfg = 16'(DT_WIN);
    @(negedge clk);
    chk_out("R6 at window", 0, 1000);

    // R8: suppression boundary
    dead_cfg = 16'd3;
    pred_on = 16'd200;
    @(negedge clk);
    chk_out("R8 shrink exceeds", DT_SH, 200);
    pred_on = 16'(DT_SH);
    @(negedge clk);
    chk_out("R8 shrink equal", DT_SH, DT_SH);
    pred_on = 16'(DT_SH + 1);
    @(negedge clk);
    chk_out("R8 one left", DT_SH, DT_SH + 1);

    // R3 random: pairs of feedback samples
    for (int t = 0; t < 40; t++) begin
      int a, b;
      a = int'($urandom_range(4000, 1));
      b = (t % 2 == 0) ? int'($urandom_range(4095, 0))
                       : ((a * 6) / 5 + int'($urandom_range(2, 0)) - 1);
      if (b > 4095) b = 4095;
      if (b < 0) b = 0;
      do_reset();
      fb_send(a);
      fb_send(b);
      chk_out("R3 random pair", exp_fb(a, b) ? FB_SH : 0, 1000);
    end

    // R6, R8 random: settings and predictions
    do_reset();
    for (int t = 0; t < 60; t++) begin
      int d, p;
      d = int'($urandom_range(60, 0));
      p = int'($urandom_range(700, 0));
      dead_cfg = 16'(d);
      pred_on = 16'(p);
      @(negedge clk);
      chk_out("R8 random", (d < DT_WIN) ? DT_SH : 0, p);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule